// File: doc/BRIEF.md
# Sixteen-Pin GPIO Register Bank with Change Interrupt

This block is a 16-pin bidirectional I/O port, organised as two 8-bit halves. Each half has four registers: a captured input value, a stored output value, a per-bit read-inversion mask and a per-bit direction mask. A bus front end outside this block turns serial traffic into simple strobes. It presents a 3-bit register index together with a write strobe and write data, or a read strobe, and then collects the read data one cycle later.

Pins configured as outputs are driven from their output register bits. Pins configured as inputs are released: their drive enable is low. Every pin level passes through a two-flop synchronizer first. The synchronized levels are what reads of the input registers return, after the inversion mask is applied. A read of an input register also captures the current levels of that half into its input register.

An active-low interrupt flags any input-direction pin whose synchronized level no longer matches the value last captured for its half. Reading the half that holds the changed pin clears the interrupt, provided no other pin still differs.

Top module: `gpio_expander`

## Requirements
- R1: While reset is high and after it is released, every pin is an input (`pin_oe` = 0x0000), `pin_out` is 0x0000 and `irq_n` is 1. A read then returns 0xFF from the output registers, 0x00 from the inversion registers and 0xFF from the direction registers.
- R2: The register index selects the register by bits: index[2:1] picks the group (0 = input, 1 = output, 2 = inversion, 3 = direction) and index[0] picks the half (0 = pins 7..0, 1 = pins 15..8).
- R3: A direction bit of 1 makes its pin an input: `pin_oe` is 0 and `pin_out` is 0 for that pin. A direction bit of 0 sets `pin_oe` to 1 and drives `pin_out` from the matching output register bit. A write takes effect at the clock edge on which the strobe is sampled.
- R4: A read of index 0 or 1 returns the synchronized pin levels of that half, whichever direction the pins are set to. Writes to index 0 and 1 change nothing.
- R5: A read of an output register returns the stored value, whatever level the pins carry.
- R6: In an input register read, each bit whose inversion bit is 1 comes back inverted, and each bit whose inversion bit is 0 comes back unchanged.
- R7: `irq_n` goes low when an input-direction pin's synchronized level differs from the captured input register bit of its half. Pins set to the output direction never cause an interrupt.
- R8: A read of an input register captures that half's synchronized levels. This clears the mismatch for that half only, and `irq_n` returns high once neither half has a mismatch.
- R9: A pin change reaches the synchronized level after two clock edges, and `irq_n` reflects it on the third edge. `rd_data` changes only on the edge after a cycle with `rd_en` high, and it holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_idx | input | 3 | Register index for the current access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, registered, valid the cycle after `rd_en` |
| pin_in | input | 16 | Sampled pin levels (asynchronous) |
| pin_out | output | 16 | Drive value for each pin |
| pin_oe | output | 16 | Drive enable for each pin, 1 = driven |
| irq_n | output | 1 | Active-low change interrupt |

## Verification
The hardest case to reach from the ports is one where both halves hold a mismatch at once and only one of them is cleared. The interrupt must then stay low, and it must release only after the second half is read. The stimulus first lets a single change settle and clears it. It then changes one pin in each half and reads the halves one at a time, sampling `irq_n` after each read has had time to reach it. A pin in the output direction is then toggled to show that it is masked. The exact edge on which a pin change first lowers `irq_n` is checked on both sides of that edge.

// File: rtl/gpio_xp_pkg.sv
package gpio_xp_pkg;
  // Register group, selected by index bits [2:1]
  typedef enum logic [1:0] {
    GRP_IN  = 2'd0,
    GRP_OUT = 2'd1,
    GRP_POL = 2'd2,
    GRP_CFG = 2'd3
  } reg_grp_e;

  localparam int IDX_W = 3;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_half.sv
module gpio_half #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_out,
  input  logic         wr_pol,
  input  logic         wr_cfg,
  input  logic [W-1:0] wdata,
  input  logic         capture,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] out_q,
  output logic [W-1:0] pol_q,
  output logic [W-1:0] cfg_q,
  output logic [W-1:0] in_view,
  output logic         pend
);
  logic [W-1:0] cap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '1;
      pol_q <= '0;
      cfg_q <= '1;
      cap_q <= '0;
    end else begin
      if (wr_out)  out_q <= wdata;
      if (wr_pol)  pol_q <= wdata;
      if (wr_cfg)  cfg_q <= wdata;
      if (capture) cap_q <= lvl;
    end
  end

  assign in_view = lvl ^ pol_q;
  // only input-direction pins can flag a change
  assign pend    = |((lvl ^ cap_q) & cfg_q);
endmodule

// File: rtl/gpio_expander.sv
module gpio_expander #(
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2:0]          reg_idx,
  input  logic                wr_en,
  input  logic [PORT_W-1:0]   wr_data,
  input  logic                rd_en,
  output logic [PORT_W-1:0]   rd_data,
  input  logic [2*PORT_W-1:0] pin_in,
  output logic [2*PORT_W-1:0] pin_out,
  output logic [2*PORT_W-1:0] pin_oe,
  output logic                irq_n
);
  import gpio_xp_pkg::*;

  localparam int HALVES = 2;
  localparam int PIN_W  = HALVES * PORT_W;

  logic [PIN_W-1:0] lvl;
  reg_grp_e         grp;
  logic             half_sel;

  logic [PORT_W-1:0] out_h  [HALVES];
  logic [PORT_W-1:0] pol_h  [HALVES];
  logic [PORT_W-1:0] cfg_h  [HALVES];
  logic [PORT_W-1:0] view_h [HALVES];
  logic [HALVES-1:0] pend_h;

  gpio_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (lvl)
  );

  assign grp      = reg_grp_e'(reg_idx[2:1]);
  assign half_sel = reg_idx[0];

  genvar h;
  generate
    for (h = 0; h < HALVES; h++) begin : g_half
      logic hit;
      assign hit = (half_sel == h[0]);

      gpio_half #(.W(PORT_W)) u_half (
        .clk     (clk),
        .rst     (rst),
        .wr_out  (wr_en && hit && grp == GRP_OUT),
        .wr_pol  (wr_en && hit && grp == GRP_POL),
        .wr_cfg  (wr_en && hit && grp == GRP_CFG),
        .wdata   (wr_data),
        .capture (rd_en && hit && grp == GRP_IN),
        .lvl     (lvl[h*PORT_W +: PORT_W]),
        .out_q   (out_h[h]),
        .pol_q   (pol_h[h]),
        .cfg_q   (cfg_h[h]),
        .in_view (view_h[h]),
        .pend    (pend_h[h])
      );

      assign pin_oe[h*PORT_W +: PORT_W]  = ~cfg_h[h];
      assign pin_out[h*PORT_W +: PORT_W] = out_h[h] & ~cfg_h[h];
    end
  endgenerate

  logic [PORT_W-1:0] rd_mux;
  always_comb begin
    unique case (grp)
      GRP_IN:  rd_mux = view_h[half_sel];
      GRP_OUT: rd_mux = out_h[half_sel];
      GRP_POL: rd_mux = pol_h[half_sel];
      default: rd_mux = cfg_h[half_sel];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      irq_n   <= 1'b1;
    end else begin
      if (rd_en) rd_data <= rd_mux;
      irq_n <= ~|pend_h;
    end
  end
endmodule

// File: rtl/gpio_expander_chk.sv
module gpio_expander_chk #(
  parameter int PORT_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic [2:0]          reg_idx,
  input logic                wr_en,
  input logic [PORT_W-1:0]   wr_data,
  input logic                rd_en,
  input logic [PORT_W-1:0]   rd_data,
  input logic [2*PORT_W-1:0] pin_out,
  input logic [2*PORT_W-1:0] pin_oe,
  input logic                irq_n
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (pin_oe == '0 && pin_out == '0 && irq_n));

  // R4
  input_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_idx[2:1] == 2'b00) |=> ($stable(pin_out) && $stable(pin_oe)));

  // R3
  oe_only_by_cfg_write_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && reg_idx[2:1] == 2'b11) |=> $stable(pin_oe));

  // R3
  out_low_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_idx == 3'd2) |=>
      (pin_out[PORT_W-1:0] == ($past(wr_data) & pin_oe[PORT_W-1:0])));

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

bind gpio_expander gpio_expander_chk #(.PORT_W(PORT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .reg_idx (reg_idx),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_en   (rd_en),
  .rd_data (rd_data),
  .pin_out (pin_out),
  .pin_oe  (pin_oe),
  .irq_n   (irq_n)
);

// File: tb/gpio_expander_bench.sv
module gpio_expander_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  reg_idx = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_data;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out;
  logic [15:0] pin_oe;
  logic        irq_n;

  int n_run  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_expander u_gpio_expander (
    .clk     (clk),
    .rst     (rst),
    .reg_idx (reg_idx),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .pin_in  (pin_in),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .irq_n   (irq_n)
  );

  typedef struct packed {
    logic [2:0]  idx;
    logic [7:0]  wd;
    logic [15:0] pins;
    logic [7:0]  exp;
  } vec_t;

  // write idx <- wd with pins applied, then read idx back
  localparam vec_t VECS [10] = '{
    '{3'd2, 8'hA5, 16'h0000, 8'hA5},  // R5 output 0
    '{3'd3, 8'h3C, 16'hFFFF, 8'h3C},  // R5 flop not pin
    '{3'd4, 8'h0F, 16'h0000, 8'h0F},  // R2 inversion 0
    '{3'd0, 8'hFF, 16'h0012, 8'h1D},  // R4 R6 write ignored, inverted
    '{3'd1, 8'h55, 16'h8100, 8'h81},  // R4 write ignored
    '{3'd5, 8'hF0, 16'h8100, 8'hF0},  // R2 inversion 1
    '{3'd1, 8'h00, 16'h8100, 8'h71},  // R6 upper half inverted
    '{3'd6, 8'h0F, 16'h0000, 8'h0F},  // R2 direction 0
    '{3'd7, 8'h00, 16'h0000, 8'h00},  // R2 direction 1
    '{3'd0, 8'h00, 16'h00AA, 8'hA5}   // R4 output-direction pins still read
  };

  task automatic check(input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_write(input logic [2:0] idx, input logic [7:0] d);
    @(negedge clk);
    reg_idx = idx; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [2:0] idx, output logic [7:0] d);
    @(negedge clk);
    reg_idx = idx; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst = 1'b1;
    wait_neg(3);
    rst = 1'b0;
  endtask

  logic [7:0] rv;

  initial begin
    pin_in = '0;
    wait_neg(3);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state at the ports
    check("R1 pin_oe", pin_oe, 16'h0000);
    check("R1 pin_out", pin_out, 16'h0000);
    check("R1 irq_n", {15'd0, irq_n}, 16'd1);
    do_read(3'd2, rv); check("R1 out0", {8'd0, rv}, 16'h00FF);
    do_read(3'd5, rv); check("R1 pol1", {8'd0, rv}, 16'h0000);
    do_read(3'd7, rv); check("R1 cfg1", {8'd0, rv}, 16'h00FF);

    for (int v = 0; v < 10; v++) begin
      @(negedge clk);
      pin_in = VECS[v].pins;
      do_write(VECS[v].idx, VECS[v].wd);
      wait_neg(3);
      do_read(VECS[v].idx, rv);
      check($sformatf("R2 vector %0d", v), {8'd0, rv}, {8'd0, VECS[v].exp});
    end

    // R3 directions: cfg0=0F cfg1=00, out0=A5 out1=3C
    check("R3 pin_oe", pin_oe, 16'hFFF0);
    check("R3 pin_out", pin_out, 16'h3CA0);

    // R9 rd_data holds without a read strobe
    pin_in = 16'h0055;
    wait_neg(4);
    check("R9 rd_data hold", {8'd0, rd_data}, 16'h00A5);

    // R1 reset restores defaults
    pin_in = '0;
    apply_reset();
    @(negedge clk);
    check("R1 pin_oe after reset", pin_oe, 16'h0000);
    do_read(3'd3, rv); check("R1 out1 after reset", {8'd0, rv}, 16'h00FF);
    do_read(3'd4, rv); check("R1 pol0 after reset", {8'd0, rv}, 16'h0000);
    do_read(3'd6, rv); check("R1 cfg0 after reset", {8'd0, rv}, 16'h00FF);
    wait_neg(3);
    check("R7 idle irq_n", {15'd0, irq_n}, 16'd1);

    // R9 latency: two sync edges, irq on the third
    pin_in[3] = 1'b1;
    wait_neg(2);
    check("R9 irq_n before third edge", {15'd0, irq_n}, 16'd1);
    wait_neg(1);
    check("R9 irq_n on third edge", {15'd0, irq_n}, 16'd0);

    // R8 read clears
    do_read(3'd0, rv);
    check("R8 capture value", {8'd0, rv}, 16'h0008);
    wait_neg(2);
    check("R8 irq_n cleared", {15'd0, irq_n}, 16'd1);

    // R8 both halves pending, clear one at a time
    pin_in[12] = 1'b1;
    pin_in[1]  = 1'b1;
    wait_neg(4);
    check("R7 irq_n two halves", {15'd0, irq_n}, 16'd0);
    do_read(3'd0, rv);
    wait_neg(2);
    check("R8 irq_n upper still pending", {15'd0, irq_n}, 16'd0);
    do_read(3'd1, rv);
    check("R8 upper capture", {8'd0, rv}, 16'h0010);
    wait_neg(2);
    check("R8 irq_n all cleared", {15'd0, irq_n}, 16'd1);

    // R7 output-direction pins are masked
    do_write(3'd7, 8'h00);
    pin_in[9] = 1'b1;
    wait_neg(5);
    check("R7 output pin no irq", {15'd0, irq_n}, 16'd1);
    do_write(3'd7, 8'hFF);
    wait_neg(2);
    check("R7 pin becomes input, irq", {15'd0, irq_n}, 16'd0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule